// File: doc/BRIEF.md
# Transparent Refresh Controller for Pseudo-SRAM

This block wraps a behavioural array of dynamic cells and presents it to the host as a plain synchronous SRAM. The host uses a select, a write enable, an address, write data, registered read data and a ready flag. Inside, the block schedules periodic refreshes of cell rows and arbitrates them against host traffic. The host goes first. Refreshes that the host defers are counted, and the block takes the bus only when that count reaches its ceiling.

A two-bit mode input picks one of three power states. Active serves the host and refreshes normally. Standby refuses the host but keeps refreshing at a slower rate, so the contents survive. Sleep stops all refresh, and the contents are then treated as gone. The power-state machine has three states: `PS_ACTIVE`, `PS_STANDBY` and `PS_SLEEP`. Its transitions are named *park* (active to standby), *resume* (standby to active), *power-down* (active or standby to sleep) and *wake* (sleep to active or standby). A wake raises a data-lost flag, and the flag stays up until the host writes a word.

Several inputs configure the refresh. A temperature class input shortens the refresh period as the temperature rises. A bypass input hands the refresh trigger to external logic. A group-size select sets how many rows one refresh operation covers. A retention limit bounds the region of rows that keeps getting refreshed. The array geometry is set by parameters. The default is a small array of 32 rows by 8 words of 8 bits, and a production build sets it to 128K words.

Top module: `psram_refresh_top`

## Requirements
- R1: In active mode with fewer than 4 pending refreshes, `ready` is high. A read with `cs`=1 and `we`=0 puts the stored byte on `rdata` at the next clock edge, and `rdata` holds it until the next accepted read. A write with `cs`=1 and `we`=1 stores `wdata` at that edge.
- R2: Host accesses win over refresh. While `cs` is high in active mode, no refresh runs until 4 refreshes are pending. At that point `ready` drops for the cycle, one refresh runs, and the host access offered in that cycle is not performed.
- R3: With bypass off and the host idle in active mode, refreshes run every 64>>`temp_sel` cycles: 64, 32, 16 or 8 cycles for `temp_sel` 0 to 3.
- R4: In standby the refresh interval is four times the active interval. `ready` is low, and host accesses are ignored. After return to active, `ready` is high in the first cycle and the earlier contents read back unchanged.
- R5: With `bypass`=1 the internal timer makes no refresh. Each cycle with `ext_rf_req` high adds one pending refresh, and that refresh runs in the next idle cycle. With `bypass`=0, `ext_rf_req` has no effect.
- R6: Each refresh reports its first row on `rf_row`, with `rf_act`=1. The row pointer then advances by 1<<`grp_sel` rows (1, 2, 4 or 8). It restarts at row 0 when the advanced value would exceed `ret_top`. A pointer that already lies above `ret_top` refreshes row 0 instead.
- R7: In sleep no refresh runs, `ready` is low and pending or requested refreshes are discarded. Reset and every wake set `data_lost` to 1. The first accepted write clears it.
- R8: `mode` encodes 2'b00 as active, 2'b01 as standby, and 2'b10 and 2'b11 as sleep. A change takes effect from the clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Power mode request |
| cs | input | 1 | Host access select |
| we | input | 1 | Host write (1) or read (0) |
| addr | input | ROW_W+COL_W | Host word address, row in upper bits |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered read data |
| ready | output | 1 | Host access accepted this cycle |
| bypass | input | 1 | External logic drives refresh requests |
| ext_rf_req | input | 1 | External refresh request, one per high cycle |
| temp_sel | input | 2 | Temperature class, higher gives a shorter period |
| grp_sel | input | 2 | Rows per refresh operation, 1<<grp_sel |
| ret_top | input | ROW_W | Last row of the retained region |
| data_lost | output | 1 | Contents invalid until rewritten |
| rf_act | output | 1 | A refresh operation runs this cycle |
| rf_row | output | ROW_W | First row of the current refresh group |

## Verification
The bench targets the pending-refresh ceiling. It checks the exact cycle in which `ready` falls, and checks that the write offered in that cycle leaves memory untouched. A design that overflows the counter or lets that write through fails one of the two checks. It sweeps every group size against several retention limits, including a limit of row 0 and a group larger than the region, and compares each reported row with an arithmetic model. An off-by-one in the wrap test shows up there. It measures refresh intervals for each temperature class and in standby, which catches a period set one cycle long or a standby rate that is not slowed. It also checks that refreshes requested during sleep do not run after wake and that wake raises the lost flag.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'd0,
        PS_STANDBY = 2'd1,
        PS_SLEEP   = 2'd2
    } pstate_e;
endpackage

// File: rtl/psr_timer.sv
// Periodic refresh tick; period scales with temperature class and standby.
module psr_timer #(
    parameter int BASE_PERIOD = 64,
    parameter int STBY_SHIFT  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       slow,
    input  logic [1:0] temp_sel,
    output logic       tick
);
    localparam int MAX_LIM = BASE_PERIOD << STBY_SHIFT;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(BASE_PERIOD >> temp_sel);
        if (slow) limit = limit << STBY_SHIFT;
        tick = run && (cnt_q >= limit - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R3: the counter never runs past the longest period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_LIM));
endmodule

// File: rtl/psr_refresh_arb.sv
// Pending-refresh accounting, host-first arbitration and the row pointer.
module psr_refresh_arb #(
    parameter int ROW_W    = 5,
    parameter int PEND_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             req,
    input  logic             host_busy,
    input  logic [1:0]       grp_sel,
    input  logic [ROW_W-1:0] ret_top,
    output logic             rf_act,
    output logic [ROW_W-1:0] rf_row,
    output logic             pend_full
);
    localparam int PEND_W = $clog2(PEND_MAX + 1);

    logic [PEND_W-1:0] pend_q;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W:0]    nxt;

    always_comb begin
        pend_full = (pend_q == PEND_W'(PEND_MAX));
        rf_act    = enable && (pend_q != '0) && (!host_busy || pend_full);
        rf_row    = (row_q > ret_top) ? '0 : row_q;
        nxt       = {1'b0, rf_row} + ((ROW_W+1)'(1) << grp_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            row_q  <= '0;
        end else begin
            if (!enable) pend_q <= '0;
            else         pend_q <= pend_q + PEND_W'(req) - PEND_W'(rf_act);
            if (rf_act)
                row_q <= (nxt > {1'b0, ret_top}) ? '0 : nxt[ROW_W-1:0];
        end
    end

    a_r2_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_W'(PEND_MAX));
    a_r6_row_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        rf_act |-> (rf_row <= ret_top));
    a_r7_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pend_q == '0));
endmodule

// File: rtl/psr_array.sv
// Behavioural cell array with a registered read port.
module psr_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
        if (rd_en) rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/psram_refresh_top.sv
module psram_refresh_top #(
    parameter int ROW_W       = 5,
    parameter int COL_W       = 3,
    parameter int DATA_W      = 8,
    parameter int BASE_PERIOD = 64,
    parameter int STBY_SHIFT  = 2,
    parameter int PEND_MAX    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode,
    input  logic                   cs,
    input  logic                   we,
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic                   ready,
    input  logic                   bypass,
    input  logic                   ext_rf_req,
    input  logic [1:0]             temp_sel,
    input  logic [1:0]             grp_sel,
    input  logic [ROW_W-1:0]       ret_top,
    output logic                   data_lost,
    output logic                   rf_act,
    output logic [ROW_W-1:0]       rf_row
);
    import psr_pkg::*;

    localparam int ADDR_W = ROW_W + COL_W;

    pstate_e state_q, state_d;
    logic    in_active, in_standby, in_sleep, waking;
    logic    tick, rf_req, pend_full, wr_acc, rd_acc, lost_q;

    // power-state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_ACTIVE;
        else        state_q <= state_d;
    end

    // next state and state outputs
    always_comb begin
        unique case (mode)
            2'b00:   state_d = PS_ACTIVE;   // resume / wake
            2'b01:   state_d = PS_STANDBY;  // park / wake
            default: state_d = PS_SLEEP;    // power-down
        endcase
        in_active  = (state_q == PS_ACTIVE);
        in_standby = (state_q == PS_STANDBY);
        in_sleep   = (state_q == PS_SLEEP);
        waking     = in_sleep && (state_d != PS_SLEEP);
    end

    always_comb begin
        ready  = in_active && !pend_full;
        wr_acc = cs && we && ready;
        rd_acc = cs && !we && ready;
        rf_req = bypass ? (ext_rf_req && !in_sleep) : tick;
    end

    psr_timer #(.BASE_PERIOD(BASE_PERIOD), .STBY_SHIFT(STBY_SHIFT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!in_sleep && !bypass),
        .slow     (in_standby),
        .temp_sel (temp_sel),
        .tick     (tick)
    );

    psr_refresh_arb #(.ROW_W(ROW_W), .PEND_MAX(PEND_MAX)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!in_sleep),
        .req       (rf_req),
        .host_busy (cs && in_active),
        .grp_sel   (grp_sel),
        .ret_top   (ret_top),
        .rf_act    (rf_act),
        .rf_row    (rf_row),
        .pend_full (pend_full)
    );

    psr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .wr_en (wr_acc),
        .rd_en (rd_acc),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lost_q <= 1'b1;
        else if (waking) lost_q <= 1'b1;
        else if (wr_acc) lost_q <= 1'b0;
    end

    assign data_lost = lost_q;

    a_r7_no_refresh_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        in_sleep |-> !rf_act);
    a_r2_host_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && ready) |-> !rf_act);
    a_r7_lost_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost_q) |-> $past(cs && we));
    a_r8_wake_marks_lost: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == PS_SLEEP && state_q != PS_SLEEP) |-> lost_q);
endmodule

// File: tb/psram_refresh_top_tb.sv
module psram_refresh_top_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode, temp_sel, grp_sel;
    logic       cs, we, bypass, ext_rf_req;
    logic [7:0] addr, wdata, rdata;
    logic [4:0] ret_top, rf_row;
    logic       ready, data_lost, rf_act;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    psram_refresh_top u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .bypass(bypass),
        .ext_rf_req(ext_rf_req), .temp_sel(temp_sel), .grp_sel(grp_sel),
        .ret_top(ret_top), .data_lost(data_lost), .rf_act(rf_act), .rf_row(rf_row)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic done();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // waits for a refresh, then counts cycles to the next one
    task automatic measure(output int iv);
        int c;
        do begin @(negedge clk); #1; end while (!rf_act);
        c = 0;
        do begin @(negedge clk); #1; c++; end while (!rf_act && c < 2000);
        iv = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        done();
    end

    initial begin
        int mrow, cnt, iv;
        int rets[4] = '{31, 9, 2, 0};
        rst_n = 0; mode = 2'b00; cs = 0; we = 0; addr = 0; wdata = 0;
        bypass = 1; ext_rf_req = 0; temp_sel = 0; grp_sel = 0; ret_top = 5'd31;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(ready == 1'b1, "R1 reset ready", ready, 1);
        chk(data_lost == 1'b1, "R7 reset lost", data_lost, 1);
        chk(rf_act == 1'b0, "R6 reset idle", rf_act, 0);

        // R6: row pointer sweep over group sizes and retention limits
        mrow = 0;
        for (int g = 0; g < 4; g++) begin
            for (int r = 0; r < 4; r++) begin
                for (int k = 0; k < 6; k++) begin
                    int base;
                    @(negedge clk);
                    grp_sel = 2'(g); ret_top = 5'(rets[r]); ext_rf_req = 1;
                    @(negedge clk); ext_rf_req = 0; #1;
                    base = (mrow > rets[r]) ? 0 : mrow;
                    chk(rf_act == 1'b1, "R5 bypass request runs", rf_act, 1);
                    chk(rf_row == 5'(base), "R6 row", rf_row, base);
                    mrow = (base + (1 << g) > rets[r]) ? 0 : base + (1 << g);
                end
            end
        end
        grp_sel = 0; ret_top = 5'd31;

        // R1: full write then read sweep
        for (int a = 0; a < 256; a++) begin
            @(negedge clk); cs = 1; we = 1; addr = 8'(a); wdata = pat(a);
        end
        @(negedge clk); cs = 0; #1;
        chk(data_lost == 1'b0, "R7 write clears lost", data_lost, 0);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk); cs = 1; we = 0; addr = 8'(a);
            @(posedge clk); #1;
            chk(rdata == pat(a), "R1 readback", rdata, pat(a));
        end

        // R2: pending ceiling under continuous host traffic
        @(negedge clk); cs = 1; we = 0; addr = 0; ext_rf_req = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(ready == 1'b1 && rf_act == 1'b0, "R2 host keeps bus", {ready, rf_act}, 2);
        end
        @(negedge clk); ext_rf_req = 0; we = 1; addr = 8'd5; wdata = ~pat(5); #1;
        chk(ready == 1'b0, "R2 ready drops at ceiling", ready, 0);
        chk(rf_act == 1'b1, "R2 forced refresh", rf_act, 1);
        @(negedge clk); we = 0; #1;
        chk(ready == 1'b1 && rf_act == 1'b0, "R2 ready back", {ready, rf_act}, 2);
        @(posedge clk); #1;
        chk(rdata == pat(5), "R2 blocked write ignored", rdata, pat(5));
        @(negedge clk); cs = 0;
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            #1; if (rf_act) cnt++;
            @(negedge clk);
        end
        chk(cnt == 3, "R2 deferred refreshes drain", cnt, 3);

        // R5: timer silent in bypass
        cnt = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); #1; if (rf_act) cnt++; end
        chk(cnt == 0, "R5 timer off in bypass", cnt, 0);

        // R3: interval per temperature class
        bypass = 0;
        for (int t = 3; t >= 0; t--) begin
            temp_sel = 2'(t);
            measure(iv); measure(iv);
            chk(iv == (64 >> t), "R3 interval", iv, 64 >> t);
        end

        // R5: external request ignored without bypass
        measure(iv);
        ext_rf_req = 1; @(negedge clk); ext_rf_req = 0;
        cnt = 0;
        for (int i = 0; i < 55; i++) begin @(negedge clk); #1; if (rf_act) cnt++; end
        chk(cnt == 0, "R5 request ignored", cnt, 0);

        // R4: standby
        @(negedge clk); mode = 2'b01;
        @(negedge clk); #1;
        chk(ready == 1'b0, "R4 standby not ready", ready, 0);
        cs = 1; we = 1; addr = 8'd7; wdata = ~pat(7);
        measure(iv); measure(iv);
        chk(iv == 256, "R4 standby interval", iv, 256);
        @(negedge clk); mode = 2'b00; cs = 0;
        @(negedge clk); #1;
        chk(ready == 1'b1, "R4 ready on resume", ready, 1);
        chk(data_lost == 1'b0, "R4 data kept", data_lost, 0);
        cs = 1; we = 0; addr = 8'd7;
        @(posedge clk); #1;
        chk(rdata == pat(7), "R4 standby write ignored", rdata, pat(7));

        // R7/R8: sleep
        @(negedge clk); cs = 0; bypass = 1; mode = 2'b10;
        @(negedge clk); #1;
        chk(ready == 1'b0, "R8 mode 10 sleeps", ready, 0);
        cnt = 0;
        ext_rf_req = 1;
        for (int i = 0; i < 5; i++) begin @(negedge clk); #1; if (rf_act) cnt++; end
        mode = 2'b11;
        @(negedge clk); #1; if (rf_act) cnt++;
        chk(ready == 1'b0, "R8 mode 11 sleeps", ready, 0);
        chk(cnt == 0, "R7 no refresh asleep", cnt, 0);
        ext_rf_req = 0; mode = 2'b00;
        @(negedge clk); #1;
        chk(ready == 1'b1, "R8 wake to active", ready, 1);
        chk(data_lost == 1'b1, "R7 wake sets lost", data_lost, 1);
        cnt = 0;
        for (int i = 0; i < 4; i++) begin if (rf_act) cnt++; @(negedge clk); #1; end
        chk(cnt == 0, "R7 sleep requests discarded", cnt, 0);
        cs = 1; we = 1; addr = 8'd3; wdata = 8'h3C;
        @(negedge clk); cs = 0; #1;
        chk(data_lost == 1'b0, "R7 rewrite clears lost", data_lost, 0);
        done();
    end
endmodule